// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the word address for every cycle of a four-beat memory burst. A load cycle (chip selected, advance input low) captures a full external address and opens a burst. Each later advance cycle steps the two low address bits to the next beat, while the upper bits stay exactly as loaded. The stepping follows one of two orders, chosen by a static mode input: interleaved, where the beat index is XORed into the start offset, or linear, where the beat index is added to the start offset modulo 4. After the fourth beat the sequence returns to the start offset and repeats for as long as advance stays high.

A load request with the chip deselected closes the burst. An advance that arrives while no burst is open does nothing. A high stall input freezes all state, as if the clock edge never happened. The address output is formed from the registered start value and the beat count, so it changes in the cycle that follows the edge that updated them.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, `addr_o` reads 0 and `burst_o` reads 0 until the first load.
- R2: At an edge with `stall_i`=0, `sel_i`=1 and `adv_i`=0, `addr_i` is captured: after that edge `addr_o` equals it and `burst_o` is 1.
- R3: With `ilv_i`=1, the low two bits of `addr_o` after the k-th advance of a burst equal start XOR (k mod 4).
- R4: With `ilv_i`=0, the low two bits of `addr_o` after the k-th advance equal (start + k) mod 4.
- R5: After four advances the low bits are back at the start offset, and the sequence keeps repeating while advance stays high.
- R6: Advance cycles never change bits above bit 1 of `addr_o`; there is no carry out of the low two bits.
- R7: At an edge with `stall_i`=0, `sel_i`=0 and `adv_i`=0, `burst_o` goes to 0 and `addr_o` keeps its value.
- R8: At an edge with `stall_i`=1, `addr_o` and `burst_o` keep their values whatever the other inputs are.
- R9: An advance (`adv_i`=1, `stall_i`=0) while `burst_o` is 0 leaves `addr_o` unchanged and `burst_o` at 0.
- R10: An advance while a burst is open steps the address even when `sel_i` is 0; chip select is only examined on load cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | 1 = ignore this edge, hold all state |
| sel_i | input | 1 | Combined chip-select result, 1 = selected |
| adv_i | input | 1 | 1 = advance the burst, 0 = load (or deselect) |
| addr_i | input | ADDR_W | External address captured on a load |
| ilv_i | input | 1 | Burst order: 1 = interleaved, 0 = linear; static |
| addr_o | output | ADDR_W | Address of the current beat |
| burst_o | output | 1 | 1 while a burst is open |

## Verification
The bench walks every start offset through more than four advances in both orders, so a sequencer that stops at the last beat, lets the step carry into bit 2, or uses addition where XOR is required shows a wrong low field or a changed upper field. It stalls in the middle of a burst, where a design that still counts would skip a beat, and it deselects mid-burst and then advances, where a design that forgets to close the burst would keep stepping. Advances with chip select low during an open burst catch a design that wrongly gates stepping on select, and random mixes of all controls compare every cycle against a bench model.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int unsigned BEATS = 4;
  localparam int unsigned OFF_W = $clog2(BEATS);

  typedef logic [OFF_W-1:0] off_t;

  // Interleaved order: beat index folded into the start by XOR.
  function automatic off_t order_xor(input off_t start, input off_t beat);
    return start ^ beat;
  endfunction

  // Linear order: beat index added to the start, wrapping in the field.
  function automatic off_t order_add(input off_t start, input off_t beat);
    return off_t'(start + beat);
  endfunction

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stall_i,
  input  logic sel_i,
  input  logic adv_i,
  output logic load_o,
  output logic step_o,
  output logic open_o
);

  logic open_q;
  logic open_d;
  logic kill;

  assign load_o = !stall_i && sel_i && !adv_i;
  assign kill   = !stall_i && !sel_i && !adv_i;
  assign step_o = !stall_i && adv_i && open_q;

  always_comb begin
    open_d = open_q;
    if (load_o) begin
      open_d = 1'b1;
    end else if (kill) begin
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
    end else begin
      open_q <= open_d;
    end
  end

  assign open_o = open_q;

  AST_KILL_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !sel_i && !adv_i) |=> !open_o); // R7

endmodule

// File: rtl/bseq_capture.sv
module bseq_capture
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:OFF_W] upper_o,
  output off_t              start_o
);

  logic [ADDR_W-1:OFF_W] upper_q, upper_d;
  off_t                  start_q, start_d;

  always_comb begin
    upper_d = upper_q;
    start_d = start_q;
    if (load_i) begin
      upper_d = addr_i[ADDR_W-1:OFF_W];
      start_d = addr_i[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= '0;
      start_q <= '0;
    end else begin
      upper_q <= upper_d;
      start_q <= start_d;
    end
  end

  assign upper_o = upper_q;
  assign start_o = start_q;

  AST_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(upper_o)); // R6

endmodule

// File: rtl/bseq_beat_cnt.sv
module bseq_beat_cnt
  import burst_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output off_t beat_o
);

  off_t beat_q, beat_d;

  always_comb begin
    beat_d = beat_q;
    if (clear_i) begin
      beat_d = '0;
    end else if (step_i) begin
      beat_d = off_t'(beat_q + 1'b1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
    end else begin
      beat_q <= beat_d;
    end
  end

  assign beat_o = beat_q;

  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (beat_o == '0)); // R2

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import burst_seq_pkg::*;
(
  input  off_t start_i,
  input  off_t beat_i,
  input  logic ilv_i,
  output off_t off_o
);

  off_t lane [2];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    if (g == 0) begin : g_lin
      assign lane[g] = order_add(start_i, beat_i);
    end else begin : g_ilv
      assign lane[g] = order_xor(start_i, beat_i);
    end
  end

  assign off_o = ilv_i ? lane[1] : lane[0];

  always_comb begin
    if (beat_i == '0) begin
      AST_BEAT0_START: assert (off_o == start_i); // R5
    end
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              sel_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ilv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              burst_o
);

  logic                  load;
  logic                  step;
  logic [ADDR_W-1:OFF_W] upper;
  off_t                  start;
  off_t                  beat;
  off_t                  off;

  bseq_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stall_i (stall_i),
    .sel_i   (sel_i),
    .adv_i   (adv_i),
    .load_o  (load),
    .step_o  (step),
    .open_o  (burst_o)
  );

  bseq_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .addr_i  (addr_i),
    .upper_o (upper),
    .start_o (start)
  );

  bseq_beat_cnt u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load),
    .step_i  (step),
    .beat_o  (beat)
  );

  bseq_order_map u_map (
    .start_i (start),
    .beat_i  (beat),
    .ilv_i   (ilv_i),
    .off_o   (off)
  );

  assign addr_o = {upper, off};

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(addr_o) && $stable(burst_o))); // R8

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && sel_i && !adv_i) |=> (burst_o && addr_o == $past(addr_i))); // R2

  AST_IDLE_NOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && adv_i && !burst_o) |=> ($stable(addr_o) && !burst_o)); // R9

  AST_STEP_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && adv_i && burst_o) |=>
      (burst_o && addr_o[OFF_W-1:0] != $past(addr_o[OFF_W-1:0]))); // R10

  AST_KILL_HOLDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !sel_i && !adv_i) |=> $stable(addr_o)); // R7

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

  localparam int CLK_PERIOD = 10;
  localparam int W = 19;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         stall_i, sel_i, adv_i, ilv_i;
  logic [W-1:0] addr_i;
  logic [W-1:0] addr_o;
  logic         burst_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [W-1:0] m_addr;
  logic [1:0]   m_cnt;
  logic         m_act;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  burst_addr_seq #(.ADDR_W(W)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .stall_i(stall_i), .sel_i(sel_i),
    .adv_i(adv_i), .addr_i(addr_i), .ilv_i(ilv_i),
    .addr_o(addr_o), .burst_o(burst_o)
  );

  function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] k,
                                         input logic ilv);
    return ilv ? (s ^ k) : 2'(s + k);
  endfunction

  function automatic logic [W-1:0] exp_addr();
    return {m_addr[W-1:2], exp_low(m_addr[1:0], m_cnt, ilv_i)};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; stall_i = 1'b0; sel_i = 1'b0; adv_i = 1'b0; addr_i = '0;
    m_addr = '0; m_cnt = '0; m_act = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 addr in reset", addr_o, '0);
    chk("R1 burst in reset", {{(W-1){1'b0}}, burst_o}, '0);
    rst_ni = 1'b1;
  endtask

  // One clock: drive at the falling edge, model at the rising edge,
  // compare a quarter period later.
  task automatic cyc_op(input string req, input logic st, input logic se,
                        input logic ad, input logic [W-1:0] a);
    @(negedge clk_i);
    stall_i = st; sel_i = se; adv_i = ad; addr_i = a;
    @(posedge clk_i);
    if (!st) begin
      if (!ad) begin
        if (se) begin m_addr = a; m_cnt = '0; m_act = 1'b1; end
        else m_act = 1'b0;
      end else if (m_act) begin
        m_cnt = m_cnt + 2'd1;
      end
    end
    #(CLK_PERIOD/4);
    chk(req, addr_o, exp_addr());
    chk(req, {{(W-1){1'b0}}, burst_o}, {{(W-1){1'b0}}, m_act});
  endtask

  initial begin
    wait (cyc > 100000);
    fails++;
    $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    ilv_i = 1'b1;
    do_reset();
    chk("R1 addr after reset", addr_o, '0);
    cyc_op("R9 advance when idle", 1'b0, 1'b1, 1'b1, 19'h7ffff);

    // Interleaved sweep of every start offset, six beats each.
    for (int s = 0; s < 4; s++) begin
      cyc_op("R2 load", 1'b0, 1'b1, 1'b0, {17'h1a5c3, 2'(s)});
      for (int k = 0; k < 6; k++) cyc_op("R3 R5 R6 interleaved step", 1'b0, 1'b1, 1'b1, '1);
    end
    // Directed: start 01 gives 01,00,11,10.
    cyc_op("R2 load 01", 1'b0, 1'b1, 1'b0, 19'h00001);
    cyc_op("R3 beat1", 1'b0, 1'b1, 1'b1, '0);
    chk("R3 expect 00", addr_o, 19'h00000);
    cyc_op("R8 stall mid burst", 1'b1, 1'b1, 1'b0, 19'h55555);
    cyc_op("R3 beat2", 1'b0, 1'b0, 1'b1, '0);
    chk("R10 expect 11 with select low", addr_o, 19'h00003);
    cyc_op("R7 deselect", 1'b0, 1'b0, 1'b0, 19'h12345);
    chk("R7 address held", addr_o, 19'h00003);
    cyc_op("R9 advance after deselect", 1'b0, 1'b1, 1'b1, '0);
    chk("R9 address unchanged", addr_o, 19'h00003);

    ilv_i = 1'b0;
    do_reset();
    for (int s = 0; s < 4; s++) begin
      cyc_op("R2 load", 1'b0, 1'b1, 1'b0, {17'h1ffff, 2'(s)});
      for (int k = 0; k < 6; k++) cyc_op("R4 R5 R6 linear step", 1'b0, 1'b1, 1'b1, '0);
    end
    // Directed: start 11 gives 11,00,01,10,11 with no carry into bit 2.
    cyc_op("R2 load 11", 1'b0, 1'b1, 1'b0, 19'h00007);
    cyc_op("R4 beat1", 1'b0, 1'b1, 1'b1, '0);
    chk("R6 no carry", addr_o, 19'h00004);
    cyc_op("R4 beat2", 1'b0, 1'b1, 1'b1, '0);
    cyc_op("R4 beat3", 1'b0, 1'b1, 1'b1, '0);
    cyc_op("R5 wrap", 1'b0, 1'b1, 1'b1, '0);
    chk("R5 back to start", addr_o, 19'h00007);

    // Random mix against the model.
    for (int mode = 0; mode < 2; mode++) begin
      ilv_i = 1'(mode);
      do_reset();
      for (int i = 0; i < 600; i++) begin
        logic st, se, ad;
        logic [W-1:0] a;
        string req;
        st = ($urandom_range(0, 99) < 15);
        se = ($urandom_range(0, 99) < 70);
        ad = ($urandom_range(0, 99) < 65);
        a  = W'($urandom);
        if (st) req = "R8 random stall";
        else if (!ad && se) req = "R2 random load";
        else if (!ad) req = "R7 random deselect";
        else if (!m_act) req = "R9 random idle advance";
        else if (!se) req = "R10 random advance unselected";
        else if (ilv_i) req = "R3 random step";
        else req = "R4 random step";
        cyc_op(req, st, se, ad, a);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule